// File: doc/BRIEF.md
# Power Domain Sequencer

This block switches one gated power domain on and off in a fixed order with timed gaps between the steps. It drives the top-level sleep enables of the domain's power switch, the memory power-down fields of its retention banks, the isolation enables, a domain reset and a domain clock enable. A request is accepted through a small request/busy/done handshake. The block reports whether the domain is powered off. Each domain in a chip gets its own instance, sized by parameters. A parameter removes the top-level switch for memory-only domains, and another removes the clocks.

The microsecond and millisecond gaps come from cycle counters. Their lengths are derived from the clock frequency parameter, and a divisor parameter shortens them for simulation. A strap sampled during reset lets the block take over a domain that is already powered when the chip starts. In that case the domain is kept on against ordinary off requests, and only the shutdown input can turn it off.

Top module: `pwr_dom_seq`

## Requirements
- R1: With the strap low during reset, these outputs hold the off state: every sleep bit is 1, every memory power-down bit is 1, every isolation bit is 1, reset is 0, clock enable is 0, busy is 0 and powered-off is 1.
- R2: An off sequence sets the sleep bits on the first edge after the request is accepted. It sets the memory bits US_CYC cycles later and the isolation bits US_CYC cycles after that. US_CYC = (CLK_HZ/1e6)*20/SIM_DIV, with a minimum of 1.
- R3: When the domain has clocks, the off sequence drops the clock enable MS_CYC cycles after isolation, in the cycle of done. MS_CYC = (CLK_HZ/1000)*20/SIM_DIV, with a minimum of 1. Without clocks, done comes with the isolation step.
- R4: An on sequence runs these steps, each timed from the previous one:
  - it clears the sleep bits on the first edge;
  - it clears the memory bits US_CYC cycles later;
  - it raises reset US_CYC cycles after that;
  - it clears isolation one cycle later, while reset is high;
  - it releases reset one cycle later;
  - it raises the clock enable, together with done, one cycle later.
- R5: mem_pd_o has 2*N_WIDE+N_NARROW bits. Wide bank k uses bits [2k+1:2k], and the one-bit banks sit above the wide banks. All fields switch together as units.
- R6: With HAS_SWITCH=0, the sleep and isolation outputs stay 0. The gaps and memory updates keep the same timing, and powered-off reflects the last completed sequence.
- R7: With a top-level switch, powered_off_o is 1 exactly when any sleep bit is 1.
- R8: busy_o is high from the first step of a sequence until the edge that raises done_o. done_o lasts one cycle. Requests and shutdown that arrive while busy_o is high are ignored.
- R9: A request for the state the domain is already in raises done_o on the next edge. busy_o stays low and no power output changes.
- R10: With the strap high during reset, the outputs hold the on state: sleep, memory and isolation bits are 0, reset is 0, and the clock enable equals HAS_CLK. always_on_o is 1 when both HAS_SWITCH and HAS_CLK are 1.
- R11: While always_on_o is 1, an off request starts nothing and gives no done_o. The outputs stay unchanged.
- R12: shutdown_i in the idle state runs the full off sequence when the domain is on, even if it is always-on, and then clears always_on_o. When the domain is off, shutdown_i has no effect. Shutdown takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_on_i | input | 1 | Domain is already powered at start (sampled in reset) |
| req_valid_i | input | 1 | Request strobe |
| req_on_i | input | 1 | Requested state: 1 on, 0 off |
| shutdown_i | input | 1 | Forced power-off request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| powered_off_o | output | 1 | Domain reported off |
| always_on_o | output | 1 | Ordinary off requests are refused |
| sleep_o | output | SLEEP_W | Top-level switch sleep enables |
| mem_pd_o | output | 2*N_WIDE+N_NARROW | Memory bank power-down fields |
| iso_o | output | ISO_W | Isolation enables |
| dom_rst_o | output | 1 | Domain reset |
| clk_en_o | output | 1 | Domain clock enable |

## Verification
The bench builds two instances at CLK_HZ=200 MHz with SIM_DIV=1000, which gives US_CYC=4 and MS_CYC=4000. At those lengths every gap and the millisecond clock-gating wait are timed edge by edge within a short run. The first instance has a two-bit switch, two-bit isolation, three wide and two narrow memory banks, and clocks. The full layout and the always-on hand-off are reachable on it. The second is a memory-only domain without clocks, which covers the skipped switch steps and the shorter off sequence.

// File: rtl/pwr_dom_seq_pkg.sv
package pwr_dom_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFF_W1,
        ST_OFF_W2,
        ST_OFF_W3,
        ST_ON_W1,
        ST_ON_W2,
        ST_ON_ISO,
        ST_ON_REL,
        ST_ON_CLK
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       sleep;
        logic       mem_pd;
        logic       iso;
        logic       dom_rst;
        logic       clk_en;
        logic       busy;
        logic       done;
        logic       on;
        logic       aon;
    } seq_regs_t;

endpackage

// File: rtl/pwr_dom_timer.sv
module pwr_dom_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_dom_mem_map.sv
module pwr_dom_mem_map #(
    parameter int N_WIDE   = 16,
    parameter int N_NARROW = 8
) (
    input  logic                         pd_i,
    output logic [2*N_WIDE+N_NARROW-1:0] field_o
);
    localparam int WIDE_BITS = 2 * N_WIDE;

    for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
        assign field_o[2*k +: 2] = {2{pd_i}};
    end

    for (genvar j = 0; j < N_NARROW; j++) begin : g_narrow
        assign field_o[WIDE_BITS + j] = pd_i;
    end
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
    import pwr_dom_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned SIM_DIV    = 1,
    parameter int          SLEEP_W    = 1,
    parameter int          ISO_W      = 1,
    parameter int          N_WIDE     = 16,
    parameter int          N_NARROW   = 8,
    parameter bit          HAS_SWITCH = 1'b1,
    parameter bit          HAS_CLK    = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         strap_on_i,
    input  logic                         req_valid_i,
    input  logic                         req_on_i,
    input  logic                         shutdown_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         powered_off_o,
    output logic                         always_on_o,
    output logic [SLEEP_W-1:0]           sleep_o,
    output logic [2*N_WIDE+N_NARROW-1:0] mem_pd_o,
    output logic [ISO_W-1:0]             iso_o,
    output logic                         dom_rst_o,
    output logic                         clk_en_o
);
    localparam int unsigned US_RAW  = (CLK_HZ / 1_000_000) * 20 / SIM_DIV;
    localparam int unsigned MS_RAW  = (CLK_HZ / 1_000) * 20 / SIM_DIV;
    localparam int unsigned US_CYC  = (US_RAW < 1) ? 1 : US_RAW;
    localparam int unsigned MS_CYC  = (MS_RAW < 1) ? 1 : MS_RAW;
    localparam int unsigned MAX_CYC = (US_CYC > MS_CYC) ? US_CYC : MS_CYC;
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] US_LOAD = CNT_W'(US_CYC - 1);
    localparam logic [CNT_W-1:0] MS_LOAD = CNT_W'(MS_CYC - 1);

    seq_regs_t        d, q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    pwr_dom_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = US_LOAD;
        unique case (q.state)
            ST_IDLE: begin
                if (shutdown_i) begin
                    if (q.on) begin
                        d.sleep  = HAS_SWITCH;
                        d.on     = 1'b0;
                        d.busy   = 1'b1;
                        tmr_load = 1'b1;
                        d.state  = ST_OFF_W1;
                    end
                end else if (req_valid_i) begin
                    if (req_on_i == q.on) begin
                        d.done = 1'b1;
                    end else if (req_on_i) begin
                        d.sleep  = 1'b0;
                        d.busy   = 1'b1;
                        tmr_load = 1'b1;
                        d.state  = ST_ON_W1;
                    end else if (!q.aon) begin
                        d.sleep  = HAS_SWITCH;
                        d.on     = 1'b0;
                        d.busy   = 1'b1;
                        tmr_load = 1'b1;
                        d.state  = ST_OFF_W1;
                    end
                end
            end
            ST_OFF_W1: if (tmr_zero) begin
                d.mem_pd = 1'b1;
                tmr_load = 1'b1;
                d.state  = ST_OFF_W2;
            end
            ST_OFF_W2: if (tmr_zero) begin
                d.iso = HAS_SWITCH;
                if (HAS_CLK) begin
                    tmr_load = 1'b1;
                    tmr_val  = MS_LOAD;
                    d.state  = ST_OFF_W3;
                end else begin
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.aon   = 1'b0;
                    d.state = ST_IDLE;
                end
            end
            ST_OFF_W3: if (tmr_zero) begin
                d.clk_en = 1'b0;
                d.busy   = 1'b0;
                d.done   = 1'b1;
                d.aon    = 1'b0;
                d.state  = ST_IDLE;
            end
            ST_ON_W1: if (tmr_zero) begin
                d.mem_pd = 1'b0;
                tmr_load = 1'b1;
                d.state  = ST_ON_W2;
            end
            ST_ON_W2: if (tmr_zero) begin
                d.dom_rst = 1'b1;
                d.state   = ST_ON_ISO;
            end
            ST_ON_ISO: begin
                d.iso   = 1'b0;
                d.state = ST_ON_REL;
            end
            ST_ON_REL: begin
                d.dom_rst = 1'b0;
                d.state   = ST_ON_CLK;
            end
            ST_ON_CLK: begin
                d.clk_en = HAS_CLK;
                d.busy   = 1'b0;
                d.done   = 1'b1;
                d.on     = 1'b1;
                d.state  = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.dom_rst <= 1'b0;
            q.busy    <= 1'b0;
            q.done    <= 1'b0;
            if (strap_on_i) begin
                q.sleep  <= 1'b0;
                q.mem_pd <= 1'b0;
                q.iso    <= 1'b0;
                q.clk_en <= HAS_CLK;
                q.on     <= 1'b1;
                q.aon    <= HAS_SWITCH & HAS_CLK;
            end else begin
                q.sleep  <= HAS_SWITCH;
                q.mem_pd <= 1'b1;
                q.iso    <= HAS_SWITCH;
                q.clk_en <= 1'b0;
                q.on     <= 1'b0;
                q.aon    <= 1'b0;
            end
        end else begin
            q <= d;
        end
    end

    pwr_dom_mem_map #(.N_WIDE(N_WIDE), .N_NARROW(N_NARROW)) mem_map_i (
        .pd_i    (q.mem_pd),
        .field_o (mem_pd_o)
    );

    assign sleep_o       = {SLEEP_W{q.sleep}};
    assign iso_o         = {ISO_W{q.iso}};
    assign dom_rst_o     = q.dom_rst;
    assign clk_en_o      = q.clk_en;
    assign busy_o        = q.busy;
    assign done_o        = q.done;
    assign always_on_o   = q.aon;
    assign powered_off_o = HAS_SWITCH ? (|sleep_o) : ~q.on;
endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk #(
    parameter int SLEEP_W    = 1,
    parameter int ISO_W      = 1,
    parameter int MEM_W      = 2,
    parameter bit HAS_SWITCH = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid_i,
    input logic               req_on_i,
    input logic               shutdown_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               always_on_o,
    input logic [SLEEP_W-1:0] sleep_o,
    input logic [MEM_W-1:0]   mem_pd_o,
    input logic [ISO_W-1:0]   iso_o,
    input logic               dom_rst_o,
    input logic               clk_en_o
);
    AST_MEM_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_SWITCH && $rose(mem_pd_o[0])) |-> sleep_o[0]);                     // R2
    AST_ISO_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_o[0]) |-> mem_pd_o[0]);                                        // R2
    AST_CLK_OFF_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_SWITCH && $fell(clk_en_o)) |-> iso_o[0]);                           // R3
    AST_MEM_ON_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_SWITCH && $fell(mem_pd_o[0])) |-> !sleep_o[0]);                    // R4
    AST_ISO_REL_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_o[0]) |-> dom_rst_o);                                          // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                     // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !req_valid_i && !shutdown_i) |=>
        ($stable(sleep_o) && $stable(mem_pd_o) && $stable(iso_o) && !busy_o));  // R8
    AST_AON_NO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (always_on_o && !busy_o && req_valid_i && !req_on_i && !shutdown_i) |=>
        (!busy_o && !done_o));                                                   // R11
endmodule

bind pwr_dom_seq pwr_dom_seq_chk #(
    .SLEEP_W    (SLEEP_W),
    .ISO_W      (ISO_W),
    .MEM_W      (2*N_WIDE+N_NARROW),
    .HAS_SWITCH (HAS_SWITCH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_on_i    (req_on_i),
    .shutdown_i  (shutdown_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .always_on_o (always_on_o),
    .sleep_o     (sleep_o),
    .mem_pd_o    (mem_pd_o),
    .iso_o       (iso_o),
    .dom_rst_o   (dom_rst_o),
    .clk_en_o    (clk_en_o)
);

// File: tb/pwr_dom_seq_tb_top.sv
module pwr_dom_seq_tb_top;
    localparam int unsigned CLK_HZ  = 200_000_000;
    localparam int unsigned SIM_DIV = 1000;
    localparam int U  = (CLK_HZ / 1_000_000) * 20 / SIM_DIV;
    localparam int M  = (CLK_HZ / 1_000) * 20 / SIM_DIV;
    localparam int SW = 2, IW = 2, NW = 3, NN = 2;
    localparam int MW = 2 * NW + NN;
    localparam int ON_LAT     = 4 + 2 * U;
    localparam int OFF_LAT    = 1 + 2 * U + M;
    localparam int MO_OFF_LAT = 1 + 2 * U;

    typedef struct packed {
        logic on;
        int   lat;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1},         // R9 already off
        '{1'b1, ON_LAT},    // R4
        '{1'b1, 1},         // R9 already on
        '{1'b0, OFF_LAT},   // R2 R3
        '{1'b1, ON_LAT},    // R4
        '{1'b0, OFF_LAT}    // R2 R3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic a_req_v = 1'b0, a_req_on = 1'b0, a_sd = 1'b0;
    logic b_req_v = 1'b0, b_req_on = 1'b0, b_sd = 1'b0;
    logic a_busy, a_done, a_poff, a_aon, a_rst, a_clk_en;
    logic b_busy, b_done, b_poff, b_aon, b_rst, b_clk_en;
    logic [SW-1:0] a_sleep;
    logic [MW-1:0] a_mem;
    logic [IW-1:0] a_iso;
    logic [0:0]    b_sleep, b_iso;
    logic [1:0]    b_mem;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwr_dom_seq #(
        .CLK_HZ(CLK_HZ), .SIM_DIV(SIM_DIV), .SLEEP_W(SW), .ISO_W(IW),
        .N_WIDE(NW), .N_NARROW(NN), .HAS_SWITCH(1'b1), .HAS_CLK(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_on_i(strap),
        .req_valid_i(a_req_v), .req_on_i(a_req_on), .shutdown_i(a_sd),
        .busy_o(a_busy), .done_o(a_done), .powered_off_o(a_poff),
        .always_on_o(a_aon), .sleep_o(a_sleep), .mem_pd_o(a_mem),
        .iso_o(a_iso), .dom_rst_o(a_rst), .clk_en_o(a_clk_en)
    );

    pwr_dom_seq #(
        .CLK_HZ(CLK_HZ), .SIM_DIV(SIM_DIV), .SLEEP_W(1), .ISO_W(1),
        .N_WIDE(1), .N_NARROW(0), .HAS_SWITCH(1'b0), .HAS_CLK(1'b0)
    ) dut_mo_i (
        .clk(clk), .rst_n(rst_n), .strap_on_i(strap),
        .req_valid_i(b_req_v), .req_on_i(b_req_on), .shutdown_i(b_sd),
        .busy_o(b_busy), .done_o(b_done), .powered_off_o(b_poff),
        .always_on_o(b_aon), .sleep_o(b_sleep), .mem_pd_o(b_mem),
        .iso_o(b_iso), .dom_rst_o(b_rst), .clk_en_o(b_clk_en)
    );

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // {done, busy, clk_en, rst, iso0, mem0, sleep0}
    function automatic logic [6:0] snap(input bit mo);
        if (mo) return {b_done, b_busy, b_clk_en, b_rst, b_iso[0], b_mem[0], b_sleep[0]};
        return {a_done, a_busy, a_clk_en, a_rst, a_iso[0], a_mem[0], a_sleep[0]};
    endfunction

    task automatic run_req(input bit mo, input bit on, input bit sd, input int exp_lat, input string rq);
        logic [6:0] p, c;
        int n = 1;
        int t_sl = -1, t_mem = -1, t_iso = -1, t_rr = -1, t_rf = -1, t_clk = -1;
        int busy_cnt = 0;
        bit seen = 1'b0;
        @(negedge clk);
        p = snap(mo);
        if (mo) begin
            if (sd) b_sd = 1'b1; else begin b_req_v = 1'b1; b_req_on = on; end
        end else begin
            if (sd) a_sd = 1'b1; else begin a_req_v = 1'b1; a_req_on = on; end
        end
        @(negedge clk);
        a_req_v = 1'b0; a_sd = 1'b0; b_req_v = 1'b0; b_sd = 1'b0;
        while (n <= exp_lat + 8) begin
            c = snap(mo);
            if (c[0] != p[0] && t_sl < 0)  t_sl = n;
            if (c[1] != p[1] && t_mem < 0) t_mem = n;
            if (c[2] != p[2] && t_iso < 0) t_iso = n;
            if (c[3] && !p[3] && t_rr < 0) t_rr = n;
            if (!c[3] && p[3] && t_rf < 0) t_rf = n;
            if (c[4] != p[4] && t_clk < 0) t_clk = n;
            if (c[5]) busy_cnt++;
            p = c;
            if (c[6]) begin seen = 1'b1; break; end
            @(negedge clk);
            n++;
        end
        if (exp_lat == 0) begin
            chk(rq, "ignored: done seen", seen, 0);
            chk(rq, "ignored: busy cycles", busy_cnt, 0);
            chk(rq, "ignored: output changes", (t_sl >= 0) + (t_mem >= 0) + (t_iso >= 0) + (t_clk >= 0), 0);
        end else begin
            chk(rq, "done latency", seen ? n : -1, exp_lat);
            chk("R8", "busy cycles before done", busy_cnt, exp_lat - 1);
            if (exp_lat == 1) begin
                chk(rq, "matching: output changes", (t_sl >= 0) + (t_mem >= 0) + (t_iso >= 0) + (t_clk >= 0), 0);
            end else if (!on) begin
                chk(rq, "off sleep step", t_sl, mo ? -1 : 1);
                chk(rq, "off memory step", t_mem, 1 + U);
                chk(rq, "off isolation step", t_iso, mo ? -1 : 1 + 2 * U);
                chk("R3", "off clock gate step", t_clk, mo ? -1 : 1 + 2 * U + M);
            end else begin
                chk(rq, "on sleep step", t_sl, mo ? -1 : 1);
                chk(rq, "on memory step", t_mem, 1 + U);
                chk(rq, "on reset rise", t_rr, 1 + 2 * U);
                chk(rq, "on isolation release", t_iso, mo ? -1 : 2 + 2 * U);
                chk(rq, "on reset release", t_rf, 3 + 2 * U);
                chk(rq, "on clock enable", t_clk, mo ? -1 : 4 + 2 * U);
            end
            @(negedge clk);
            c = snap(mo);
            chk("R8", "done width", c[6], 0);
            chk("R8", "busy after done", c[5], 0);
            if (mo) begin
                chk(rq, "final memory", b_mem, on ? 0 : 3);
                chk("R6", "final powered_off", b_poff, !on);
            end else begin
                chk(rq, "final memory", a_mem, on ? 0 : {MW{1'b1}});
                chk("R7", "final powered_off", a_poff, !on);
                chk("R7", "final sleep", a_sleep, on ? 0 : {SW{1'b1}});
            end
        end
    endtask

    task automatic do_reset(input logic s);
        strap = s;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(120_000 * 5);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        // R1 reset state
        chk("R1", "sleep", a_sleep, {SW{1'b1}});
        chk("R1", "memory", a_mem, {MW{1'b1}});
        chk("R1", "isolation", a_iso, {IW{1'b1}});
        chk("R1", "reset", a_rst, 0);
        chk("R1", "clock enable", a_clk_en, 0);
        chk("R1", "busy", a_busy, 0);
        chk("R7", "powered_off", a_poff, 1);
        chk("R6", "mo sleep/iso held", {b_sleep, b_iso}, 0);

        for (int i = 0; i < 6; i++) begin
            run_req(1'b0, VECS[i].on, 1'b0, VECS[i].lat, VECS[i].lat == 1 ? "R9" : (VECS[i].on ? "R4" : "R2"));
        end

        // R8: requests and shutdown during busy are ignored
        run_req(1'b0, 1'b1, 1'b0, ON_LAT, "R4");
        @(negedge clk);
        a_req_v = 1'b1; a_req_on = 1'b0;
        @(negedge clk);
        a_req_v = 1'b0;
        repeat (3) @(negedge clk);
        a_req_v = 1'b1; a_req_on = 1'b1; a_sd = 1'b1;
        @(negedge clk);
        a_req_v = 1'b0; a_sd = 1'b0;
        for (int k = 0; k < OFF_LAT + 20 && !a_done; k++) @(negedge clk);
        chk("R8", "done reached", a_done, 1);
        chk("R8", "state after ignored on request", a_sleep, {SW{1'b1}});
        repeat (3) @(negedge clk);
        chk("R8", "no second sequence", a_busy, 0);
        chk("R8", "memory stays off", a_mem, {MW{1'b1}});

        // R6 memory-only domain from off
        run_req(1'b1, 1'b1, 1'b0, ON_LAT, "R6");
        chk("R6", "mo sleep/iso held", {b_sleep, b_iso}, 0);
        run_req(1'b1, 1'b0, 1'b0, MO_OFF_LAT, "R6");
        chk("R5", "mo memory field width", $bits(b_mem), 2);

        // R10 strap hand-off
        do_reset(1'b1);
        chk("R10", "sleep", a_sleep, 0);
        chk("R10", "memory", a_mem, 0);
        chk("R10", "isolation", a_iso, 0);
        chk("R10", "clock enable", a_clk_en, 1);
        chk("R10", "always_on", a_aon, 1);
        chk("R10", "powered_off", a_poff, 0);
        chk("R10", "mo always_on", b_aon, 0);
        chk("R10", "mo clock enable", b_clk_en, 0);
        chk("R5", "memory width", $bits(a_mem), MW);

        // R11 off request refused
        run_req(1'b0, 1'b0, 1'b0, 0, "R11");
        chk("R11", "still on", a_poff, 0);
        chk("R11", "still always_on", a_aon, 1);
        run_req(1'b0, 1'b1, 1'b0, 1, "R9");

        // R12 shutdown
        run_req(1'b0, 1'b0, 1'b1, OFF_LAT, "R12");
        chk("R12", "always_on cleared", a_aon, 0);
        run_req(1'b0, 1'b0, 1'b1, 0, "R12");
        chk("R12", "still off", a_mem, {MW{1'b1}});

        // R6 memory-only from strap-on
        run_req(1'b1, 1'b0, 1'b0, MO_OFF_LAT, "R6");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule